// File: doc/BRIEF.md
# PWM Carrier and Power-Frequency Timebase

This block derives the two timing rates of a three-phase PWM waveform generator from a single master clock. A prescaler divides the master clock by n, and each prescaler output advances a carrier counter that runs through 512 positions per carrier period. The carrier frequency is therefore the master clock divided by 512·n. The divisor n is chosen by a 3-bit carrier code, where code c selects n = 2^c. Code 010 gives n = 4, and code 000 gives the fastest carrier.

The second output is a phase-advance strobe for the waveform sequencer. It fires m times per carrier period, with m = 2^f selected by a 3-bit range code. A sequencer that steps its phase by 1/384 of a power cycle on each strobe tops out at a power frequency of carrier·m/384. A one-cycle carrier-start pulse marks each wrap of the counter back to zero.

A synchronous counter-clear input holds the prescaler and the counter at zero, and keeps both pulses low while it is held. The carrier code should be settled before the downstream timing is configured, because every other rate is scaled from the carrier.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `carrier_count` = 0, `carrier_start` = 0 and `phase_stb` = 0.
- R2: While `ctr_clr` is high at a clock edge, the prescaler and counter are forced to zero and both pulses are low. After `ctr_clr` is released, the first advance to count 1 happens n clocks later.
- R3: `carrier_count` advances by exactly one every n = 2^`cfs_code` master clocks. Code 010 gives one advance per 4 clocks.
- R4: `carrier_count` wraps from 511 to 0, so the interval between carrier starts is 512·n clocks.
- R5: `carrier_start` is high for exactly one clock, in the first cycle where `carrier_count` has wrapped to 0. It does not fire on the release of a clear.
- R6: `phase_stb` is high for one clock each time the counter advances to a multiple of 512/m, where m = 2^`frs_code`. This gives m strobes per carrier period, so code 100 gives 16.
- R7: With `frs_code` = 000 there is exactly one strobe per carrier period, in the same cycle as `carrier_start`.
- R8: A change of `cfs_code` takes effect at once. If the prescaler has already reached the new n−1, the counter advances on the next clock.
- R9: With `frs_code` = 111, the strobe fires on every fourth advance, which is 128 per carrier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctr_clr | input | 1 | Synchronous counter clear; holds counters at zero while high |
| cfs_code | input | 3 | Carrier divisor code, n = 2^code |
| frs_code | input | 3 | Power-range code, m = 2^code strobes per carrier |
| carrier_count | output | 9 | Position within the carrier period, 0 to 511 |
| carrier_start | output | 1 | One-cycle pulse when the count wraps to zero |
| phase_stb | output | 1 | One-cycle phase-advance strobe |

## Verification
A wrong prescaler state shows up as a count advance that comes early or late. The reference model sees this on the first mismatched clock, which is at most n cycles after the fault. A corrupted counter or strobe mask appears at the ports within one advance, either as a skipped or repeated count value or as a strobe at a position that is not a multiple of 512/m. Period and strobe totals are also measured across whole carrier periods. These totals catch errors in wrap and decode that the cycle-by-cycle compare could in principle share with a wrong model.

// File: rtl/ptb_pkg.sv
// Package: shared constants and helpers for the PWM timebase.
// Assumes code words select power-of-two divisors and multipliers.
package ptb_pkg;
    localparam int unsigned PTB_CNT_W = 9;   // 512 ticks per carrier
    localparam int unsigned PTB_SEL_W = 3;   // width of the select codes

    // Terminal prescaler value for a carrier code: 2^code - 1.
    function automatic int unsigned div_limit(input int unsigned code);
        return (32'd1 << code) - 32'd1;
    endfunction
endpackage

// File: rtl/ptb_prescaler.sv
// Module: ptb_prescaler
// Divides the master clock by n = 2^cfs_code and emits a one-cycle tick
// enable. Assumes cfs_code may change at any time; the >= compare makes
// a shrinking divisor take effect on the next clock.
module ptb_prescaler #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned PSC_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] cfs_code,
    output logic             tick
);
    import ptb_pkg::*;

    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] limit;

    // Decode the carrier code into the prescaler terminal value.
    always_comb limit = PSC_W'(div_limit(32'(cfs_code)));

    // Tick when the prescaler has reached (or passed) the terminal value.
    always_comb tick = (psc_q >= limit);

    // Prescaler register: clear, wrap on tick, otherwise count up.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            psc_q <= '0;
        end else if (tick) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptb_carrier_counter.sv
// Module: ptb_carrier_counter
// Counts prescaler ticks modulo 2^CNT_W and registers a one-cycle start
// pulse on the wrap to zero. Assumes tick is a single-cycle enable.
module ptb_carrier_counter #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] next_count,
    output logic             start
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic wrap;

    // Next position and wrap detection for the current tick.
    always_comb begin
        next_count = count + 1'b1;
        wrap       = tick && (count == CNT_MAX);
    end

    // Counter register: cleared, advanced on tick, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (tick) begin
            count <= next_count;
        end
    end

    // Start pulse register: high for the first cycle after a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            start <= 1'b0;
        end else begin
            start <= wrap;
        end
    end
endmodule

// File: rtl/ptb_phase_strobe.sv
// Module: ptb_phase_strobe
// Emits the phase-advance strobe when the counter advances to a multiple
// of 2^CNT_W / 2^frs_code. Assumes frs codes beyond CNT_W saturate to one
// strobe per tick.
module ptb_phase_strobe #(
    parameter int unsigned CNT_W = 9,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] frs_code,
    input  logic [CNT_W-1:0] next_count,
    output logic             phase_stb
);
    logic [CNT_W-1:0] mask;
    logic             aligned;

    // Build the low-bit mask: bit i must be zero when i < CNT_W - frs.
    generate
        for (genvar i = 0; i < CNT_W; i++) begin : g_mask
            always_comb mask[i] = ((i + 32'(frs_code)) < CNT_W);
        end
    endgenerate

    // Alignment of the position the counter is about to take.
    always_comb aligned = ((next_count & mask) == '0);

    // Strobe register: one cycle per aligned advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_stb <= 1'b0;
        end else begin
            phase_stb <= tick && aligned;
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
// Module: pwm_timebase (top)
// Carrier and power-frequency timebase: master clock / (2^CNT_W * n)
// carrier, with m phase strobes per carrier. Assumes synchronous
// active-low reset and synchronous counter clear.
module pwm_timebase #(
    parameter int unsigned CNT_W = ptb_pkg::PTB_CNT_W,
    parameter int unsigned SEL_W = ptb_pkg::PTB_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctr_clr,
    input  logic [SEL_W-1:0] cfs_code,
    input  logic [SEL_W-1:0] frs_code,
    output logic [CNT_W-1:0] carrier_count,
    output logic             carrier_start,
    output logic             phase_stb
);
    localparam int unsigned PSC_W = (1 << SEL_W) - 1;

    logic             tick;
    logic [CNT_W-1:0] next_count;

    ptb_prescaler #(.SEL_W(SEL_W), .PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctr_clr),
        .cfs_code (cfs_code),
        .tick     (tick)
    );

    ptb_carrier_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ctr_clr),
        .tick       (tick),
        .count      (carrier_count),
        .next_count (next_count),
        .start      (carrier_start)
    );

    ptb_phase_strobe #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_stb (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ctr_clr),
        .tick       (tick),
        .frs_code   (frs_code),
        .next_count (next_count),
        .phase_stb  (phase_stb)
    );
endmodule

// File: rtl/ptb_checker.sv
// Module: ptb_checker
// Port-level properties of pwm_timebase, attached by bind.
module ptb_checker #(
    parameter int unsigned CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctr_clr,
    input logic [CNT_W-1:0] carrier_count,
    input logic             carrier_start,
    input logic             phase_stb
);
    // R1: reset drives the outputs to their idle values.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (carrier_count == '0 && !carrier_start && !phase_stb));

    // R2: clear holds everything at zero.
    assert_clear_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_clr |=> (carrier_count == '0 && !carrier_start && !phase_stb));

    // R3: the count only ever moves by one step (mod 2^CNT_W).
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n || ctr_clr)
        ($past(rst_n) && !$past(ctr_clr) && carrier_count != $past(carrier_count))
        |-> carrier_count == CNT_W'($past(carrier_count) + 1'b1));

    // R5: the start pulse marks count zero and lasts one cycle.
    assert_start_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_start |-> carrier_count == '0);
    assert_start_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_start |=> !carrier_start);

    // R6: a strobe only accompanies a counter advance.
    assert_stb_on_advance_R6: assert property (@(posedge clk) disable iff (!rst_n || ctr_clr)
        phase_stb |-> carrier_count != $past(carrier_count));

    // R7: a carrier start is always also a phase position.
    assert_start_has_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_start |-> phase_stb);
endmodule

bind pwm_timebase ptb_checker #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctr_clr       (ctr_clr),
    .carrier_count (carrier_count),
    .carrier_start (carrier_start),
    .phase_stb     (phase_stb)
);

// File: tb/pwm_timebase_tb_top.sv
module pwm_timebase_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctr_clr = 1'b0;
    logic [2:0] cfs_code = 3'd2;
    logic [2:0] frs_code = 3'd4;
    logic [8:0] carrier_count;
    logic       carrier_start;
    logic       phase_stb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    int m_psc = 0, m_cnt = 0, m_start = 0, m_stb = 0;

    always #5 clk = ~clk;

    pwm_timebase dut_i (
        .clk(clk), .rst_n(rst_n), .ctr_clr(ctr_clr),
        .cfs_code(cfs_code), .frs_code(frs_code),
        .carrier_count(carrier_count), .carrier_start(carrier_start),
        .phase_stb(phase_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: divide, count, and pulse from the requirements.
    always @(posedge clk) begin
        if (!rst_n || ctr_clr) begin
            m_psc = 0; m_cnt = 0; m_start = 0; m_stb = 0;
        end else if (m_psc >= (1 << cfs_code) - 1) begin
            m_psc   = 0;
            m_start = (m_cnt == 511) ? 1 : 0;
            m_cnt   = (m_cnt + 1) % 512;
            m_stb   = ((m_cnt % (512 >> frs_code)) == 0) ? 1 : 0;
        end else begin
            m_psc++; m_start = 0; m_stb = 0;
        end
    end

    // Per-cycle compare, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check("R3 count", int'(carrier_count), m_cnt);
            check("R5 start", int'(carrier_start), m_start);
            check("R6 strobe", int'(phase_stb), m_stb);
        end
    end

    // Measure one carrier period: cycles and strobes between starts.
    task automatic measure(output int cycles, output int stbs, output int coinc);
        cycles = 0; stbs = 0; coinc = 0;
        do @(negedge clk); while (!carrier_start);
        do begin
            @(negedge clk);
            cycles++;
            if (phase_stb) stbs++;
        end while (!carrier_start);
        coinc = int'(phase_stb);
    endtask

    initial begin
        int cyc, st, co, first;
        repeat (3) @(negedge clk);
        check("R1 count", int'(carrier_count), 0);
        check("R1 start", int'(carrier_start), 0);
        check("R1 strobe", int'(phase_stb), 0);

        // R2: clear held, then released.
        rst_n = 1'b1; ctr_clr = 1'b1;
        repeat (10) @(negedge clk);
        check("R2 held count", int'(carrier_count), 0);
        ctr_clr = 1'b0;
        first = 0;
        do begin @(negedge clk); first++; end while (carrier_count == 0 && first < 20);
        check("R2 first advance delay", first, 4);

        // R3/R4/R6: n=4, m=16.
        measure(cyc, st, co);
        check("R4 period n=4", cyc, 2048);
        check("R6 strobes m=16", st, 16);

        // R4/R7: n=1, m=1.
        cfs_code = 3'd0; frs_code = 3'd0;
        measure(cyc, st, co);
        measure(cyc, st, co);
        check("R4 period n=1", cyc, 512);
        check("R7 strobes m=1", st, 1);
        check("R7 strobe with start", co, 1);

        // R9: n=2, m=128.
        cfs_code = 3'd1; frs_code = 3'd7;
        measure(cyc, st, co);
        measure(cyc, st, co);
        check("R9 period n=2", cyc, 1024);
        check("R9 strobes m=128", st, 128);

        // R8: long divisor, then shrink it mid-count.
        cfs_code = 3'd7;
        repeat (300) @(negedge clk);
        first = int'(carrier_count);
        cfs_code = 3'd0;
        @(negedge clk);
        check("R8 immediate advance", int'(carrier_count), (first + 1) % 512);

        // R2/R5: clear mid-run, no start on release.
        repeat (20) @(negedge clk);
        ctr_clr = 1'b1;
        @(negedge clk);
        check("R2 clear mid-run", int'(carrier_count), 0);
        ctr_clr = 1'b0;
        @(negedge clk);
        check("R5 no start on release", int'(carrier_start), 0);

        // R1: reset mid-run.
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", int'(carrier_count), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule